// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a clocked monostable pulse generator. A qualifying edge on either of its two trigger pins starts an output pulse whose length, in clock cycles, comes from the `width_i` bus at the moment the trigger is accepted. One trigger pin reacts to a rising edge and the other to a falling edge. Each pin is enabled only while the other sits at its idle level, so the two pins gate each other. The block drives a true output and a complementary output.

A mode pin chooses between two behaviours. In restarting mode, a trigger during a pulse starts the full length again from that trigger. In hold-off mode, a trigger during a pulse is dropped. A clear pin overrides everything else: it forces the outputs inactive in the same cycle, ends any pulse, and discards any trigger that is detected while it is high. Both trigger pins pass through a two-flop synchronizer and then an edge stage, so the time from trigger to output is a constant three clock edges whatever width is programmed. A second channel is simply a second instance.

Top module: `oneshot_pulse`

## Requirements
- R1: While `rst_n` is low, and after it is released with no trigger applied, `q_o` is 0 and `qn_o` is 1. No pulse appears at power-up.
- R2: A 0-to-1 change on `trig_rise_i` starts a pulse if `trig_fall_i` is 1. The change is driven between clock edges and first sampled at edge k. `q_o` is then first high after edge k+2.
- R3: A 1-to-0 change on `trig_fall_i` starts a pulse if `trig_rise_i` is 0. The timing is the same as in R2.
- R4: A rising edge on `trig_rise_i` while `trig_fall_i` is 0 starts no pulse. A falling edge on `trig_fall_i` while `trig_rise_i` is 1 starts no pulse. Opposite-direction edges on either pin never start a pulse.
- R5: An accepted trigger with `width_i` = W > 0 holds `q_o` high for exactly W consecutive clock cycles.
- R6: A trigger accepted while `width_i` is 0 has no effect.
- R7: With `retrig_i` = 1, a valid trigger during a pulse reloads W. `q_o` then stays high until W cycles after that trigger's load edge.
- R8: With `retrig_i` = 0, triggers detected while the pulse is active are ignored, and the pulse ends after its original W cycles.
- R9: While `clr_i` is 1, `q_o` is 0 and `qn_o` is 1 in that same cycle, with no clock edge needed. The pulse in progress is ended and does not resume after `clr_i` falls.
- R10: A trigger edge whose detection edge falls while `clr_i` is 1 is discarded. It does not start a pulse after `clr_i` is released, even if the trigger level is still held.
- R11: `qn_o` is always the complement of `q_o`.
- R12: The trigger-to-output latency of R2 and R3 is the same for every width value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clear, active high, overrides triggers and outputs |
| trig_rise_i | input | 1 | Trigger that fires on a rising edge; idle level 0 |
| trig_fall_i | input | 1 | Trigger that fires on a falling edge; idle level 1 |
| retrig_i | input | 1 | 1 = restarting mode, 0 = hold-off mode |
| width_i | input | WB | Pulse length in clock cycles, sampled at each accepted trigger |
| q_o | output | 1 | True pulse output |
| qn_o | output | 1 | Complementary pulse output |

## Verification
Two events can meet in the same clock edge: a trigger reaching the detection stage and an active clear. The bench provokes this by raising the clear exactly on the edge where a trigger driven two edges earlier is detected, and by raising it in the middle of a running pulse. It judges the result at the ports: the output must be low in the cycle the clear goes high, and no pulse may follow after release while the trigger level is still held. A second meeting point is a retrigger landing inside a running countdown. The bench measures the total high run and compares it with the restart length in one mode and the original length in the other.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // One detected trigger event per cycle, split by source pin.
  typedef struct packed {
    logic rise_hit;
    logic fall_hit;
  } trig_evt_t;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic d_o
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign d_o = chain[STAGES-1];
endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
  import oneshot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise_lvl_i,
  input  logic      fall_lvl_i,
  output trig_evt_t evt_o
);
  logic rise_prev;
  logic fall_prev;

  // Previous levels start at the idle values so reset makes no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_prev <= 1'b0;
      fall_prev <= 1'b1;
    end else begin
      rise_prev <= rise_lvl_i;
      fall_prev <= fall_lvl_i;
    end
  end

  // Each pin is enabled only while the other one sits at its idle level.
  always_comb begin
    evt_o.rise_hit = rise_lvl_i & ~rise_prev & fall_lvl_i;
    evt_o.fall_hit = ~fall_lvl_i & fall_prev & ~rise_lvl_i;
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int WB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          evt_any_i,
  input  logic          retrig_i,
  input  logic [WB-1:0] width_i,
  output logic          active_o,
  output logic [WB-1:0] cnt_o
);
  logic [WB-1:0] cnt;
  logic          load;

  assign active_o = (cnt != '0);
  assign load     = evt_any_i & (width_i != '0) & (retrig_i | ~active_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr_i)    cnt <= '0;
    else if (load)     cnt <= width_i;
    else if (active_o) cnt <= cnt - 1'b1;
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int WB          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          trig_rise_i,
  input  logic          trig_fall_i,
  input  logic          retrig_i,
  input  logic [WB-1:0] width_i,
  output logic          q_o,
  output logic          qn_o
);
  logic          rise_lvl;
  logic          fall_lvl;
  trig_evt_t     evt;
  logic          evt_any;
  logic          active;
  logic [WB-1:0] cnt;

  oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rise (
    .clk(clk), .rst_n(rst_n), .d_i(trig_rise_i), .d_o(rise_lvl)
  );

  oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_fall (
    .clk(clk), .rst_n(rst_n), .d_i(trig_fall_i), .d_o(fall_lvl)
  );

  oneshot_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .rise_lvl_i(rise_lvl), .fall_lvl_i(fall_lvl), .evt_o(evt)
  );

  assign evt_any = evt.rise_hit | evt.fall_hit;

  oneshot_timer #(.WB(WB)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .evt_any_i(evt_any),
    .retrig_i(retrig_i), .width_i(width_i), .active_o(active), .cnt_o(cnt)
  );

  // Clear masks the outputs combinationally; the count is zeroed at the edge.
  assign q_o  = active & ~clr_i;
  assign qn_o = ~q_o;
endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
  parameter int WB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_i,
  input logic          retrig_i,
  input logic [WB-1:0] width_i,
  input logic          evt_any,
  input logic          active,
  input logic [WB-1:0] cnt
);
  // R9
  clr_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt == '0));

  // R10
  clr_over_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_any) |=> !active);

  // R2, R3
  trig_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(evt_any));

  // R8
  nonretrig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrig_i && active && !clr_i) |=> (cnt == $past(cnt) - 1'b1));

  // R5
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !evt_any && !clr_i) |=> (cnt == $past(cnt) - 1'b1));

  // R6
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_any && (width_i == '0) && !active && !clr_i) |=> !active);
endmodule

bind oneshot_pulse oneshot_pulse_chk #(.WB(WB)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .retrig_i(retrig_i),
  .width_i(width_i), .evt_any(evt_any), .active(active), .cnt(cnt)
);

// File: tb/oneshot_pulse_tb_top.sv
module oneshot_pulse_tb_top;
  localparam int CLK_PER = 10;
  localparam int WB      = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_i = 1'b0;
  logic          trig_rise_i = 1'b0;
  logic          trig_fall_i = 1'b1;
  logic          retrig_i = 1'b1;
  logic [WB-1:0] width_i = '0;
  logic          q_o;
  logic          qn_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  oneshot_pulse #(.WB(WB), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .trig_rise_i(trig_rise_i),
    .trig_fall_i(trig_fall_i), .retrig_i(retrig_i), .width_i(width_i),
    .q_o(q_o), .qn_o(qn_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: history of sampled pins plus a remaining-cycles integer.
  logic a_h[$];
  logic b_h[$];
  int   m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_h = '{1'b0, 1'b0, 1'b0};
      b_h = '{1'b1, 1'b1, 1'b1};
      m_left = 0;
    end else begin
      bit ev;
      ev = (a_h[1] && !a_h[2] && b_h[1]) || (!b_h[1] && b_h[2] && !a_h[1]);
      if (clr_i) m_left = 0;
      else if (ev && width_i != 0 && (retrig_i || m_left == 0)) m_left = int'(width_i);
      else if (m_left > 0) m_left = m_left - 1;
      a_h.push_front(trig_rise_i); void'(a_h.pop_back());
      b_h.push_front(trig_fall_i); void'(b_h.pop_back());
    end
  end

  // Cycle-by-cycle comparison plus run-length monitor.
  int  cyc = 0;
  int  rise_cyc = 0;
  int  n_rise = 0;
  int  run = 0;
  int  last_run = 0;
  logic q_prev = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(q_o == 1'b0 && qn_o == 1'b1, "R1 outputs during reset", int'(q_o), 0);
    end else begin
      bit exp_q;
      exp_q = (m_left != 0) && !clr_i;
      chk(q_o == exp_q, "R2/R5/R9 model q", int'(q_o), int'(exp_q));
      chk(qn_o == !q_o, "R11 complement", int'(qn_o), int'(!q_o));
    end
    if (q_o && !q_prev) begin
      rise_cyc = cyc;
      n_rise++;
    end
    if (q_o) run++;
    else if (run > 0) begin
      last_run = run;
      run = 0;
    end
    q_prev = q_o;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PER * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0;
    int nr;
    tick(3);
    rst_n = 1'b1;
    tick(6);
    // R1: no pulse after reset release
    chk(n_rise == 0 && q_o == 0 && qn_o == 1, "R1 idle after reset", n_rise, 0);

    // R2 / R5 / R12: rising trigger, width 5
    width_i = 8'd5;
    trig_rise_i = 1'b1; c0 = cyc;
    tick(12);
    chk(rise_cyc - c0 == 3, "R2 latency", rise_cyc - c0, 3);
    chk(last_run == 5, "R5 length 5", last_run, 5);
    trig_rise_i = 1'b0; tick(4);

    // R3 / R5 / R12: falling trigger, width 9
    width_i = 8'd9;
    trig_fall_i = 1'b0; c0 = cyc;
    tick(15);
    chk(rise_cyc - c0 == 3, "R12 latency at width 9", rise_cyc - c0, 3);
    chk(last_run == 9, "R3 length 9", last_run, 9);
    trig_fall_i = 1'b1; tick(4);

    // R4: gated edges
    width_i = 8'd3;
    trig_rise_i = 1'b1; tick(10);
    nr = n_rise;
    trig_fall_i = 1'b0; tick(8);
    trig_rise_i = 1'b0; tick(8);
    trig_rise_i = 1'b1; tick(8);
    trig_rise_i = 1'b0; tick(4);
    trig_fall_i = 1'b1; tick(6);
    chk(n_rise == nr && q_o == 0, "R4 gated edges", n_rise - nr, 0);

    // R6: zero width
    width_i = 8'd0; nr = n_rise;
    trig_rise_i = 1'b1; tick(10);
    chk(n_rise == nr, "R6 zero width", n_rise - nr, 0);
    trig_rise_i = 1'b0; tick(3);

    // R7: restart in retrigger mode
    width_i = 8'd8; retrig_i = 1'b1;
    trig_rise_i = 1'b1; c0 = cyc;
    tick(2); trig_rise_i = 1'b0;
    tick(2); trig_rise_i = 1'b1;
    tick(20);
    chk(last_run == 12, "R7 restarted run", last_run, 12);
    trig_rise_i = 1'b0; tick(4);

    // R8: hold-off mode ignores the second trigger
    retrig_i = 1'b0; nr = n_rise;
    trig_rise_i = 1'b1;
    tick(2); trig_rise_i = 1'b0;
    tick(2); trig_rise_i = 1'b1;
    tick(20);
    chk(last_run == 8, "R8 run not extended", last_run, 8);
    chk(n_rise - nr == 1, "R8 single pulse", n_rise - nr, 1);
    trig_rise_i = 1'b0; tick(4);

    // R9: clear mid-pulse acts in the same cycle and does not resume
    retrig_i = 1'b1; width_i = 8'd20; nr = n_rise;
    trig_rise_i = 1'b1; tick(6);
    chk(q_o == 1, "R9 pulse running before clear", int'(q_o), 1);
    clr_i = 1'b1;
    @(negedge clk);
    chk(q_o == 0 && qn_o == 1, "R9 immediate clear", int'(q_o), 0);
    tick(3); clr_i = 1'b0;
    tick(30);
    chk(n_rise - nr == 1 && q_o == 0, "R9 no resume", n_rise - nr, 1);
    trig_rise_i = 1'b0; tick(3);

    // R10: clear on the detection edge discards the trigger
    width_i = 8'd6; nr = n_rise;
    trig_rise_i = 1'b1;
    tick(2); clr_i = 1'b1;
    tick(1); clr_i = 1'b0;
    tick(15);
    chk(n_rise == nr && q_o == 0, "R10 trigger discarded", n_rise - nr, 0);
    trig_rise_i = 1'b0; tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule